// File: doc/BRIEF.md
# Dual-Mode Comparator / Deadband PWM

This block is an 8-bit unit with two modes. In compare mode it takes two operands, a positive and a negative one, and on every active clock edge it registers whether they are equal and whether the positive one is strictly larger. In PWM mode it runs a free 256-step period counter. It turns the positive operand into a duty threshold and drives two complementary switch controls, one for the high side and one for the low side. Whenever the drive changes direction, it inserts a programmable dead time in which both controls are off.

Each operand can come from an external data port, from one of four shared 8-bit constant registers chosen by a fixed index, or from the constant register picked by a 2-bit matrix select. A build parameter reverses the mapping of the matrix select, so that two instances sharing the same select lines see the registers in opposite order. A power-down input clears the block. An optional mode also powers it down while its input clock is reported as halted. A clock-invert input moves all activity to the falling edge.

Top module: `cmp_pwm`

## Requirements
- R1: In compare mode (`pwm_mode`=0), each active edge registers `eq` = (P == N) and `out_p` = (P > N, unsigned), where P and N are the selected operands. `out_n` stays 0.
- R2: Operand selector encoding, the same for `pos_sel` and `neg_sel`: values 0 to 3 pick constant register 0 to 3, value 4 picks the matrix-selected register, and values 5 to 7 pick the external port (`pos_ext` / `neg_ext`). Register k sits at `const_regs[8k+7:8k]`.
- R3: With `MATRIX_REVERSE`=0, `mtx_sel` value m selects register m. With `MATRIX_REVERSE`=1 it selects register 3-m.
- R4: In PWM mode an 8-bit counter advances on every active edge and wraps at 256. The duty threshold T is P when `duty_plus1`=0 and P+1 when `duty_plus1`=1. The internal pulse is high while the counter is below T, so T=0 gives a pulse that is always low and T=256 gives one that is always high.
- R5: In PWM mode, `out_p` follows the pulse and `out_n` follows its inverse. Each time the pulse changes, both outputs are held at 0 for D = `DT_UNIT` << `dead_sel` active edges before the new state is driven. Over one steady period, `out_p` is high for max(0, T-D) edges and `out_n` is high for max(0, 256-T-D) edges, except that T=0 gives 0/256 and T=256 gives 256/0. `out_p` and `out_n` are never both 1.
- R6: In PWM mode `eq` is 0.
- R7: While `pwr_down`=1, all outputs are 0 at once, without waiting for a clock edge. On the next active edge the period counter returns to 0, so after release the first PWM edge sees counter value 0.
- R8: When `halt_pd_en`=1 and `clk_halted`=1, the block behaves as in R7. When `halt_pd_en`=0, `clk_halted` has no effect.
- R9: With `clk_inv`=0 the block acts on the rising edge of `clk`. With `clk_inv`=1 it acts on the falling edge, and rising edges change nothing.
- R10: While `rst_n`=0 (asynchronous, active low), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_inv | input | 1 | 1 = act on falling edge |
| pwr_down | input | 1 | 1 = block powered down |
| halt_pd_en | input | 1 | Enable power-down while clock halted |
| clk_halted | input | 1 | Indication that the input clock is stopped |
| pwm_mode | input | 1 | 0 = compare, 1 = PWM |
| duty_plus1 | input | 1 | Duty threshold P (0) or P+1 (1) |
| dead_sel | input | 2 | Dead time select, D = DT_UNIT << dead_sel |
| mtx_sel | input | 2 | Matrix register select |
| pos_sel | input | 3 | Positive operand source |
| neg_sel | input | 3 | Negative operand source |
| pos_ext | input | 8 | External positive operand |
| neg_ext | input | 8 | External negative operand |
| const_regs | input | 32 | Four shared constant registers |
| eq | output | 1 | Equality result (compare mode) |
| out_p | output | 1 | Greater-than result / high-side drive |
| out_n | output | 1 | Low-side drive (PWM mode) |

## Verification
Several properties are checked on every active edge. The compare result must match the operands registered one edge earlier. The two drives must never be on together, and neither may turn on in the same edge that the other turns off. `eq` stays low in PWM mode, `out_n` stays low in compare mode, and the counter is 0 after any power-down edge. Other behaviours can only be shown by the bench's scenarios: the on-time of each drive over a full period for given duty values, range settings and dead times; the operand and matrix mappings on both instance variants; the immediate effect of power-down and halt gating; and the edge on which activity occurs under clock inversion.

// File: rtl/cmp_pwm.sv
module cmp_pwm #(
  parameter int W = 8,
  parameter bit MATRIX_REVERSE = 1'b0,
  parameter int DT_UNIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_inv,
  input  logic         pwr_down,
  input  logic         halt_pd_en,
  input  logic         clk_halted,
  input  logic         pwm_mode,
  input  logic         duty_plus1,
  input  logic [1:0]   dead_sel,
  input  logic [1:0]   mtx_sel,
  input  logic [2:0]   pos_sel,
  input  logic [2:0]   neg_sel,
  input  logic [W-1:0] pos_ext,
  input  logic [W-1:0] neg_ext,
  input  logic [4*W-1:0] const_regs,
  output logic         eq,
  output logic         out_p,
  output logic         out_n
);
  localparam int NREG  = 4;
  localparam int DTMAX = DT_UNIT * 8;
  localparam int DW    = $clog2(DTMAX + 1);

  logic [W-1:0]  creg [NREG];
  logic [W-1:0]  op_p, op_n;
  logic [W-1:0]  cnt;
  logic [W:0]    thr;
  logic [DW-1:0] dead, dt;
  logic [1:0]    mtx_idx;
  logic          clk_act, pd_eff, pulse, lvl, eq_q, p_q, n_q;

  for (genvar k = 0; k < NREG; k++) begin : g_creg
    assign creg[k] = const_regs[k*W +: W];
  end

  assign clk_act = clk ^ clk_inv;
  assign pd_eff  = pwr_down | (halt_pd_en & clk_halted);
  assign mtx_idx = MATRIX_REVERSE ? ~mtx_sel : mtx_sel;

  always_comb begin
    case (pos_sel)
      3'd0, 3'd1, 3'd2, 3'd3: op_p = creg[pos_sel[1:0]];
      3'd4:                   op_p = creg[mtx_idx];
      default:                op_p = pos_ext;
    endcase
    case (neg_sel)
      3'd0, 3'd1, 3'd2, 3'd3: op_n = creg[neg_sel[1:0]];
      3'd4:                   op_n = creg[mtx_idx];
      default:                op_n = neg_ext;
    endcase
  end

  assign thr   = {1'b0, op_p} + {{W{1'b0}}, duty_plus1};
  assign pulse = {1'b0, cnt} < thr;
  assign dt    = DW'(DT_UNIT) << dead_sel;

  always_ff @(posedge clk_act or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; lvl <= 1'b0; dead <= '0;
      eq_q <= 1'b0; p_q <= 1'b0; n_q <= 1'b0;
    end else if (pd_eff) begin
      cnt <= '0; lvl <= 1'b0; dead <= '0;
      eq_q <= 1'b0; p_q <= 1'b0; n_q <= 1'b0;
    end else if (!pwm_mode) begin
      cnt  <= '0;
      lvl  <= 1'b0;
      dead <= '0;
      eq_q <= (op_p == op_n);
      p_q  <= (op_p > op_n);
      n_q  <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      eq_q <= 1'b0;
      if (pulse != lvl) begin
        lvl  <= pulse;
        dead <= dt;
        p_q  <= 1'b0;
        n_q  <= 1'b0;
      end else if (dead > DW'(1)) begin
        dead <= dead - 1'b1;
        p_q  <= 1'b0;
        n_q  <= 1'b0;
      end else begin
        dead <= '0;
        p_q  <= lvl;
        n_q  <= ~lvl;
      end
    end
  end

  assign eq    = eq_q & ~pd_eff;
  assign out_p = p_q  & ~pd_eff;
  assign out_n = n_q  & ~pd_eff;

  // R1
  cmp_result_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
    (!pwm_mode && !pd_eff) |=> (pd_eff || (eq == ($past(op_p) == $past(op_n)) && out_p == ($past(op_p) > $past(op_n)))));
  // R1
  cmp_low_side_off_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
    !pwm_mode |=> !out_n);
  // R5
  no_overlap_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
    !(out_p && out_n));
  // R5
  break_before_make_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
    (pwm_mode && ($rose(out_p) || $rose(out_n))) |-> !($past(out_p) || $past(out_n)));
  // R6
  pwm_eq_low_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
    (pwm_mode && !pd_eff) |=> !eq);
  // R7
  pd_counter_clear_chk: assert property (@(posedge clk_act) disable iff (!rst_n)
    pd_eff |=> (cnt == '0));
endmodule

// File: tb/cmp_pwm_tb_top.sv
`timescale 1ns/1ps
module cmp_pwm_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clk_inv = 1'b0, pwr_down = 1'b0;
  logic halt_pd_en = 1'b0, clk_halted = 1'b0, pwm_mode = 1'b0, duty_plus1 = 1'b0;
  logic [1:0] dead_sel = 2'd0, mtx_sel = 2'd0;
  logic [2:0] pos_sel = 3'd5, neg_sel = 3'd5;
  logic [7:0] pos_ext = 8'd0, neg_ext = 8'd0;
  logic [31:0] const_regs = {8'h00, 8'hFF, 8'h80, 8'h10};
  logic eq, out_p, out_n, eq_r, out_p_r, out_n_r;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_pwm #(.W(8), .MATRIX_REVERSE(1'b0), .DT_UNIT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_inv(clk_inv), .pwr_down(pwr_down),
    .halt_pd_en(halt_pd_en), .clk_halted(clk_halted), .pwm_mode(pwm_mode),
    .duty_plus1(duty_plus1), .dead_sel(dead_sel), .mtx_sel(mtx_sel),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .pos_ext(pos_ext), .neg_ext(neg_ext),
    .const_regs(const_regs), .eq(eq), .out_p(out_p), .out_n(out_n));

  cmp_pwm #(.W(8), .MATRIX_REVERSE(1'b1), .DT_UNIT(1)) dut_rev_i (
    .clk(clk), .rst_n(rst_n), .clk_inv(clk_inv), .pwr_down(pwr_down),
    .halt_pd_en(halt_pd_en), .clk_halted(clk_halted), .pwm_mode(pwm_mode),
    .duty_plus1(duty_plus1), .dead_sel(dead_sel), .mtx_sel(mtx_sel),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .pos_ext(pos_ext), .neg_ext(neg_ext),
    .const_regs(const_regs), .eq(eq_r), .out_p(out_p_r), .out_n(out_n_r));

  // {pos_sel, neg_sel, mtx_sel, pos_ext, neg_ext, exp_eq, exp_gt}; regs: 0=10 1=80 2=FF 3=00
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {3'd5, 3'd5, 2'd0, 8'd5,   8'd5,   1'b1, 1'b0},
    {3'd5, 3'd6, 2'd0, 8'd200, 8'd100, 1'b0, 1'b1},
    {3'd7, 3'd5, 2'd0, 8'd100, 8'd200, 1'b0, 1'b0},
    {3'd5, 3'd5, 2'd0, 8'd0,   8'd255, 1'b0, 1'b0},
    {3'd5, 3'd5, 2'd0, 8'd255, 8'd0,   1'b0, 1'b1},
    {3'd2, 3'd5, 2'd0, 8'd0,   8'hFF,  1'b1, 1'b0},
    {3'd1, 3'd0, 2'd0, 8'd0,   8'd0,   1'b0, 1'b1},
    {3'd4, 3'd5, 2'd0, 8'd0,   8'h10,  1'b1, 1'b0},
    {3'd4, 3'd5, 2'd3, 8'd0,   8'h01,  1'b0, 1'b0},
    {3'd5, 3'd4, 2'd1, 8'h7F,  8'd0,   1'b0, 1'b0},
    {3'd5, 3'd4, 2'd1, 8'h81,  8'd0,   1'b0, 1'b1},
    {3'd3, 3'd3, 2'd0, 8'd0,   8'd0,   1'b1, 1'b0}
  };

  task automatic tick();
    if (clk_inv) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic pwm_run(input int v, input bit b, input int d);
    int t, dt, ehp, ehn, hp, hn, he, ov;
    t = v + int'(b); dt = 1 << d;
    if (t == 0) begin ehp = 0; ehn = 256; end
    else if (t == 256) begin ehp = 256; ehn = 0; end
    else begin
      ehp = (t - dt > 0) ? t - dt : 0;
      ehn = (256 - t - dt > 0) ? 256 - t - dt : 0;
    end
    pwm_mode = 1'b1; pos_sel = 3'd5; pos_ext = 8'(v); duty_plus1 = b; dead_sel = 2'(d);
    pwr_down = 1'b1; tick(); pwr_down = 1'b0;
    repeat (300) tick();
    hp = 0; hn = 0; he = 0; ov = 0;
    for (int i = 0; i < 256; i++) begin
      tick();
      hp += int'(out_p); hn += int'(out_n); he += int'(eq); ov += int'(out_p & out_n);
    end
    chk($sformatf("R4 R5 high-side on-time v=%0d b=%0d d=%0d", v, b, d), hp, ehp);
    chk($sformatf("R5 low-side on-time v=%0d b=%0d d=%0d", v, b, d), hn, ehn);
    chk("R5 overlap count", ov, 0);
    chk("R6 eq high count in PWM", he, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #12;
    // R10: reset state
    chk("R10 eq in reset", int'(eq), 0);
    chk("R10 out_p in reset", int'(out_p), 0);
    chk("R10 out_n in reset", int'(out_n), 0);
    @(negedge clk); #1; rst_n = 1'b1;
    tick();

    // R1 R2 R3: vector table
    for (int i = 0; i < NV; i++) begin
      {pos_sel, neg_sel, mtx_sel, pos_ext, neg_ext} = VEC[i][25:2];
      tick();
      chk($sformatf("R1 R2 R3 eq vec%0d", i), int'(eq), int'(VEC[i][1]));
      chk($sformatf("R1 R2 R3 out_p vec%0d", i), int'(out_p), int'(VEC[i][0]));
      chk($sformatf("R1 out_n vec%0d", i), int'(out_n), 0);
    end

    // R3: reversed instance, mtx 0 -> reg3 (00), mtx 3 -> reg0 (10)
    pos_sel = 3'd4; neg_sel = 3'd5; mtx_sel = 2'd0; neg_ext = 8'h00;
    tick();
    chk("R3 reversed mtx0 eq", int'(eq_r), 1);
    chk("R3 normal mtx0 eq", int'(eq), 0);
    mtx_sel = 2'd3; neg_ext = 8'h10;
    tick();
    chk("R3 reversed mtx3 eq", int'(eq_r), 1);
    chk("R3 normal mtx3 eq", int'(eq), 0);

    // R7 R8: immediate gating in compare mode
    pos_sel = 3'd5; pos_ext = 8'd9; neg_ext = 8'd3;
    tick();
    chk("R1 out_p 9>3", int'(out_p), 1);
    pwr_down = 1'b1; #0.5;
    chk("R7 out_p gated by power-down", int'(out_p), 0);
    pwr_down = 1'b0; tick();
    chk("R7 out_p after power-down release", int'(out_p), 1);
    halt_pd_en = 1'b1; clk_halted = 1'b1; #0.5;
    chk("R8 out_p gated by halt", int'(out_p), 0);
    halt_pd_en = 1'b0; #0.5;
    chk("R8 halt ignored when disabled", int'(out_p), 1);
    tick();
    chk("R8 still running with halt ignored", int'(out_p), 1);
    clk_halted = 1'b0;

    // R4 R5 R6: PWM period measurements
    pwm_run(64, 1'b0, 0);
    pwm_run(64, 1'b1, 1);
    pwm_run(128, 1'b0, 2);
    pwm_run(0, 1'b0, 3);
    pwm_run(255, 1'b1, 3);
    pwm_run(255, 1'b0, 3);
    pwm_run(2, 1'b0, 3);

    // R7: counter restart after power-down
    pwm_run(64, 1'b0, 0);
    pwr_down = 1'b1; #0.5;
    chk("R7 PWM out_p gated", int'(out_p), 0);
    chk("R7 PWM out_n gated", int'(out_n), 0);
    #0.5; tick(); pwr_down = 1'b0;
    tick();
    chk("R7 dead edge after restart", int'(out_p), 0);
    tick();
    chk("R7 high-side on at count 1", int'(out_p), 1);
    repeat (62) tick();
    chk("R7 high-side on at count 63", int'(out_p), 1);
    tick();
    chk("R7 high-side off at count 64", int'(out_p), 0);

    // R9: clock inversion
    rst_n = 1'b0; pwm_mode = 1'b0; pos_ext = 8'd9; neg_ext = 8'd3;
    #3; clk_inv = 1'b1; #3;
    @(negedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 no update on rising edge", int'(out_p), 0);
    @(negedge clk); #1;
    chk("R9 update on falling edge", int'(out_p), 1);
    finish_run();
  end
endmodule